// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This block sits beside the flags logic of a processor core that supports virtual-8086 extensions and protected-mode virtual interrupts. For every decoded instruction that can read or write the interrupt flag (set, clear, push flags, pop flags, interrupt return, software interrupt) it decides one of three outcomes. The instruction either updates the flag state, raises a general-protection fault, or leaves the flags untouched. The decision depends on the operating mode, the privilege levels and two enable bits of the control register.

The block holds the architectural interrupt flag (IF), the virtual interrupt flag (VIF) and the virtual-interrupt-pending flag (VIP). While virtualization is active, writes to IF from code below the required privilege go to VIF instead. An attempt to enable interrupts while VIP is set faults before anything changes. VIP is changed only through a separate write port, which models system software editing the stacked flags image.

Instructions arrive on a valid/ready stream. Results leave on a second valid/ready stream through a single output register. An instruction is accepted only when that register is empty or is being drained in the same cycle, so back-pressure on the result side stalls the instruction side. Flag state changes at the edge where an instruction is accepted.

Top module: `vifc_unit`

## Requirements
- R1: After reset, IF, VIF and VIP are 0, no result is valid, and `op_ready` is 1.
- R2: `op_ready` is 1 exactly when the result register is empty or `res_ready` is 1. While `res_valid` is 1 and `res_ready` is 0, the result fields hold steady and no new instruction is accepted, so the flags do not change.
- R3: Op codes are set=0, clear=1, pushf=2, popf=3, iret=4, intn=5. Modes are real=0, protected=1, virtual-8086=2, long=3. Outside real mode, the effective privilege is `op_cpl`, or 3 in virtual-8086 mode. An instruction that is not virtualized raises a fault (kind 2) when `op_iopl` is below the effective privilege, and then IF and VIF keep their values. Real mode never faults.
- R4: A non-faulting set or clear writes IF to 1 or 0. A non-faulting popf or iret writes IF from `op_pop_if`. VIF is unchanged in both cases.
- R5: In virtual-8086 mode with `cr4_en[0]` set and `op_iopl` below 3, set and clear write VIF and leave IF unchanged. Popf writes VIF from `op_pop_if`, and iret faults.
- R6: On that virtualized path, a set, or a popf with `op_pop_if`=1, faults when VIP is 1, and VIF is not modified.
- R7: With `cr4_en[1]` set, in protected or long mode at `op_cpl`=3 with `op_iopl` below 3, set and clear act on VIF, with the same VIP fault as R6. Pushf, popf, iret and intn still fault on that path. `cr4_en[1]` has no effect in virtual-8086 mode.
- R8: `cr4_en[0]` has no effect outside virtual-8086 mode, long mode included.
- R9: A non-faulting intn is delivered through a gate: `res_gate`=1, kind 1, `res_vector` equals `op_vector`, and the image carries the IF and VIF values from before the instruction. It clears VIF on the R5 path and clears IF otherwise.
- R10: VIP changes only on a cycle where `sw_vip_we` is 1. It then takes `sw_vip_val`, whatever instruction is executing.
- R11: Pushf never changes a flag and yields kind 0 when it does not fault. Its image IF bit is VIF on the R5 path and IF otherwise.
- R12: Every result carries exactly one kind: 0 (no change), 1 (update) or 2 (fault). `res_image` holds IF at bit 9, VIF at bit 19 and VIP at bit 20, all with their values from before the instruction, except as stated in R11. Every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present |
| op_ready | output | 1 | Instruction accepted this cycle when valid |
| op_class | input | 3 | Instruction code (R3) |
| op_mode | input | 2 | Operating mode code (R3) |
| op_cpl | input | PRIV_W | Current privilege level |
| op_iopl | input | PRIV_W | I/O privilege field |
| cr4_en | input | 2 | Bit 0 enables virtual-8086 extensions, bit 1 enables protected-mode virtual interrupts |
| op_pop_if | input | 1 | IF bit of the popped flags image |
| op_vector | input | VEC_W | Software interrupt vector |
| sw_vip_we | input | 1 | Write strobe for VIP |
| sw_vip_val | input | 1 | Value written to VIP |
| flag_if | output | 1 | Current IF |
| flag_vif | output | 1 | Current VIF |
| flag_vip | output | 1 | Current VIP |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_kind | output | 2 | Outcome code (R12) |
| res_gate | output | 1 | Interrupt delivered through a gate |
| res_vector | output | VEC_W | Vector of the delivered interrupt |
| res_image | output | EFL_W | Flags image (R12) |

## Verification
The assertions assume that instruction fields are meaningful only while `op_valid` is high. They also assume that `op_class` never carries the unused codes 6 and 7, and that VIP writes are the only way VIP can move. The stimulus drives only the six defined op codes, holds the result side ready except in the dedicated stall test, and changes VIP only through `sw_vip_we`. The sweep puts IF and VIF into each starting state using legal instructions: a real-mode set or clear for IF, then a virtualized set or clear with VIP cleared for VIF. It then writes the VIP value the case needs, so every starting state is reached through the normal interface.

// File: rtl/vifc_pkg.sv
package vifc_pkg;

  typedef enum logic [2:0] {
    OP_STI   = 3'd0,
    OP_CLI   = 3'd1,
    OP_PUSHF = 3'd2,
    OP_POPF  = 3'd3,
    OP_IRET  = 3'd4,
    OP_INTN  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_UPD  = 2'd1,
    KIND_GP   = 2'd2
  } kind_e;

  localparam int CR4_V86X_BIT = 0;
  localparam int CR4_PMVI_BIT = 1;
  localparam int CR4_W        = 2;

  localparam int IMG_IF_BIT  = 9;
  localparam int IMG_VIF_BIT = 19;
  localparam int IMG_VIP_BIT = 20;

  typedef struct packed {
    kind_e kind;
    logic  gate;
    logic  nxt_if;
    logic  nxt_vif;
    logic  img_if;
    logic  img_vif;
    logic  img_vip;
  } decision_t;

  typedef struct packed {
    logic fault;
    logic v86x_path;
    logic pmvi_path;
  } priv_t;

endpackage

// File: rtl/vifc_priv_check.sv
module vifc_priv_check
  import vifc_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic [1:0]        mode,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  input  logic [CR4_W-1:0]  cr4,
  output priv_t             priv
);
  localparam logic [PRIV_W-1:0] LEAST_PRIV = {PRIV_W{1'b1}};

  logic [PRIV_W-1:0] eff_cpl;
  logic              is_v86;
  logic              is_pm_like;
  logic              iopl_low;

  always_comb begin
    is_v86     = (mode == MODE_V86);
    is_pm_like = (mode == MODE_PROT) || (mode == MODE_LONG);
    eff_cpl    = is_v86 ? LEAST_PRIV : cpl;
    iopl_low   = (iopl != LEAST_PRIV);
  end

  always_comb begin
    priv.fault     = (mode != MODE_REAL) && (iopl < eff_cpl);
    priv.v86x_path = cr4[CR4_V86X_BIT] && is_v86 && iopl_low;
    priv.pmvi_path = cr4[CR4_PMVI_BIT] && is_pm_like &&
                     (cpl == LEAST_PRIV) && iopl_low;
  end

endmodule

// File: rtl/vifc_decide.sv
module vifc_decide
  import vifc_pkg::*;
(
  input  logic [2:0] op,
  input  priv_t      priv,
  input  logic       cur_if,
  input  logic       cur_vif,
  input  logic       cur_vip,
  input  logic       pop_if,
  output decision_t  dec
);
  logic virt_setclr;

  always_comb begin
    virt_setclr = priv.v86x_path || priv.pmvi_path;

    dec         = '0;
    dec.kind    = KIND_NONE;
    dec.nxt_if  = cur_if;
    dec.nxt_vif = cur_vif;
    dec.img_if  = cur_if;
    dec.img_vif = cur_vif;
    dec.img_vip = cur_vip;

    case (op)
      OP_STI: begin
        if (!priv.fault) begin
          dec.kind   = KIND_UPD;
          dec.nxt_if = 1'b1;
        end else if (virt_setclr && !cur_vip) begin
          dec.kind    = KIND_UPD;
          dec.nxt_vif = 1'b1;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      OP_CLI: begin
        if (!priv.fault) begin
          dec.kind   = KIND_UPD;
          dec.nxt_if = 1'b0;
        end else if (virt_setclr) begin
          dec.kind    = KIND_UPD;
          dec.nxt_vif = 1'b0;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      OP_PUSHF: begin
        if (!priv.fault) begin
          dec.kind = KIND_NONE;
        end else if (priv.v86x_path) begin
          dec.kind   = KIND_NONE;
          dec.img_if = cur_vif;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      OP_POPF: begin
        if (!priv.fault) begin
          dec.kind   = KIND_UPD;
          dec.nxt_if = pop_if;
        end else if (priv.v86x_path && !(pop_if && cur_vip)) begin
          dec.kind    = KIND_UPD;
          dec.nxt_vif = pop_if;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      OP_IRET: begin
        if (!priv.fault) begin
          dec.kind   = KIND_UPD;
          dec.nxt_if = pop_if;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      OP_INTN: begin
        if (!priv.fault) begin
          dec.kind   = KIND_UPD;
          dec.gate   = 1'b1;
          dec.nxt_if = 1'b0;
        end else if (priv.v86x_path) begin
          dec.kind    = KIND_UPD;
          dec.gate    = 1'b1;
          dec.nxt_vif = 1'b0;
        end else begin
          dec.kind = KIND_GP;
        end
      end
      default: begin
        dec.kind = KIND_GP;
      end
    endcase
  end

endmodule

// File: rtl/vifc_flag_reg.sv
module vifc_flag_reg
  import vifc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      apply,
  input  decision_t dec,
  input  logic      vip_we,
  input  logic      vip_val,
  output logic      q_if,
  output logic      q_vif,
  output logic      q_vip
);
  logic take_upd;

  always_comb take_upd = apply && (dec.kind == KIND_UPD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_if  <= 1'b0;
      q_vif <= 1'b0;
    end else if (take_upd) begin
      q_if  <= dec.nxt_if;
      q_vif <= dec.nxt_vif;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_vip <= 1'b0;
    else if (vip_we) q_vip <= vip_val;
  end

endmodule

// File: rtl/vifc_result_reg.sv
module vifc_result_reg
  import vifc_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int EFL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  decision_t        dec,
  input  logic [VEC_W-1:0] vector,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic             out_gate,
  output logic [VEC_W-1:0] out_vector,
  output logic [EFL_W-1:0] out_image
);
  logic [EFL_W-1:0] image_d;

  always_comb begin
    image_d              = '0;
    image_d[IMG_IF_BIT]  = dec.img_if;
    image_d[IMG_VIF_BIT] = dec.img_vif;
    image_d[IMG_VIP_BIT] = dec.img_vip;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_kind   <= KIND_NONE;
      out_gate   <= 1'b0;
      out_vector <= '0;
      out_image  <= '0;
    end else if (in_ready && in_valid) begin
      out_kind   <= dec.kind;
      out_gate   <= dec.gate;
      out_vector <= vector;
      out_image  <= image_d;
    end
  end

endmodule

// File: rtl/vifc_unit.sv
module vifc_unit
  import vifc_pkg::*;
#(
  parameter int PRIV_W = 2,
  parameter int VEC_W  = 8,
  parameter int EFL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_class,
  input  logic [1:0]        op_mode,
  input  logic [PRIV_W-1:0] op_cpl,
  input  logic [PRIV_W-1:0] op_iopl,
  input  logic [1:0]        cr4_en,
  input  logic              op_pop_if,
  input  logic [VEC_W-1:0]  op_vector,
  input  logic              sw_vip_we,
  input  logic              sw_vip_val,
  output logic              flag_if,
  output logic              flag_vif,
  output logic              flag_vip,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic              res_gate,
  output logic [VEC_W-1:0]  res_vector,
  output logic [EFL_W-1:0]  res_image
);
  priv_t     priv;
  decision_t dec;
  logic      op_fire;

  assign op_fire = op_valid && op_ready;

  vifc_priv_check #(.PRIV_W(PRIV_W)) u_priv (
    .mode (op_mode),
    .cpl  (op_cpl),
    .iopl (op_iopl),
    .cr4  (cr4_en),
    .priv (priv)
  );

  vifc_decide u_dec (
    .op      (op_class),
    .priv    (priv),
    .cur_if  (flag_if),
    .cur_vif (flag_vif),
    .cur_vip (flag_vip),
    .pop_if  (op_pop_if),
    .dec     (dec)
  );

  vifc_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply   (op_fire),
    .dec     (dec),
    .vip_we  (sw_vip_we),
    .vip_val (sw_vip_val),
    .q_if    (flag_if),
    .q_vif   (flag_vif),
    .q_vip   (flag_vip)
  );

  vifc_result_reg #(.VEC_W(VEC_W), .EFL_W(EFL_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (op_valid),
    .in_ready   (op_ready),
    .dec        (dec),
    .vector     (op_vector),
    .out_valid  (res_valid),
    .out_ready  (res_ready),
    .out_kind   (res_kind),
    .out_gate   (res_gate),
    .out_vector (res_vector),
    .out_image  (res_image)
  );

endmodule

// File: rtl/vifc_checker.sv
module vifc_checker #(
  parameter int PRIV_W = 2,
  parameter int EFL_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_class,
  input logic [1:0]        op_mode,
  input logic [PRIV_W-1:0] op_iopl,
  input logic [1:0]        cr4_en,
  input logic              sw_vip_we,
  input logic              flag_if,
  input logic              flag_vif,
  input logic              flag_vip,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_kind,
  input logic              res_gate,
  input logic [EFL_W-1:0]  res_image
);
  localparam logic [PRIV_W-1:0] TOP_PRIV = {PRIV_W{1'b1}};

  logic fire;
  logic v86_virt;
  assign fire     = op_valid && op_ready;
  assign v86_virt = (op_mode == 2'd2) && cr4_en[0] && (op_iopl != TOP_PRIV);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_kind) && $stable(res_image)) // R2
    else $error("stall hold");

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !op_ready) // R2
    else $error("stall blocks");

  AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (res_kind != 2'd2) || (flag_if == $past(flag_if) && flag_vif == $past(flag_vif))) // R3
    else $error("fault changed flags");

  AST_REAL_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_mode == 2'd0 |=> res_kind != 2'd2) // R3
    else $error("real mode fault");

  AST_V86_IF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_class <= 3'd1 && v86_virt |=> flag_if == $past(flag_if)) // R5
    else $error("IF changed on virtual path");

  AST_VIP_SET_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_class == 3'd0 && v86_virt && flag_vip |=> res_kind == 2'd2) // R6
    else $error("set with VIP did not fault");

  AST_VIP_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_vip_we |=> $stable(flag_vip)) // R10
    else $error("VIP moved without write");

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_kind != 2'd3) // R12
    else $error("illegal kind");

  AST_GATE_IS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_gate |-> res_kind == 2'd1) // R9
    else $error("gate without update");

endmodule

bind vifc_unit vifc_checker #(.PRIV_W(PRIV_W), .EFL_W(EFL_W)) u_chk (.*);

// File: tb/vifc_unit_test.sv
module vifc_unit_test;
  localparam int PRIV_W = 2;
  localparam int VEC_W  = 8;
  localparam int EFL_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic              op_ready;
  logic [2:0]        op_class = '0;
  logic [1:0]        op_mode = '0;
  logic [PRIV_W-1:0] op_cpl = '0;
  logic [PRIV_W-1:0] op_iopl = '0;
  logic [1:0]        cr4_en = '0;
  logic              op_pop_if = 1'b0;
  logic [VEC_W-1:0]  op_vector = '0;
  logic              sw_vip_we = 1'b0;
  logic              sw_vip_val = 1'b0;
  logic              flag_if, flag_vif, flag_vip;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [1:0]        res_kind;
  logic              res_gate;
  logic [VEC_W-1:0]  res_vector;
  logic [EFL_W-1:0]  res_image;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vifc_unit #(.PRIV_W(PRIV_W), .VEC_W(VEC_W), .EFL_W(EFL_W)) uut (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(input int op, input int mode, input int cpl, input int iopl,
                       input int cr4, input bit pop, input int vec);
    @(negedge clk);
    op_class = 3'(op); op_mode = 2'(mode); op_cpl = PRIV_W'(cpl);
    op_iopl = PRIV_W'(iopl); cr4_en = 2'(cr4); op_pop_if = pop;
    op_vector = VEC_W'(vec); op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic write_vip(input bit v);
    @(negedge clk);
    sw_vip_we = 1'b1; sw_vip_val = v;
    @(posedge clk);
    @(negedge clk);
    sw_vip_we = 1'b0;
  endtask

  task automatic put_state(input bit i, input bit v, input bit p);
    write_vip(1'b0);
    issue(i ? 0 : 1, 0, 0, 0, 0, 1'b0, 0);
    issue(v ? 0 : 1, 2, 3, 0, 1, 1'b0, 0);
    write_vip(p);
  endtask

  // Reference outcome from the requirements.
  task automatic model(input int op, input int mode, input int cpl, input int iopl,
                       input int cr4, input bit ci, input bit cv, input bit cp,
                       input bit pop, output int kind, output bit ni, output bit nv,
                       output bit gate, output bit img_if, output string tag);
    int  eff;
    bit  flt, v86p, pmp;
    eff  = (mode == 2) ? 3 : cpl;
    flt  = (mode != 0) && (iopl < eff);
    v86p = cr4[0] && mode == 2 && iopl < 3;
    pmp  = cr4[1] && (mode == 1 || mode == 3) && cpl == 3 && iopl < 3;
    kind = 2; ni = ci; nv = cv; gate = 0; img_if = ci;
    tag = flt ? (v86p ? "R5" : (pmp ? "R7" : "R3")) : "R4";
    if (cr4[0] && mode != 2) tag = "R8";
    if (op == 0 || op == 1) begin
      if (!flt) begin kind = 1; ni = (op == 0); end
      else if (v86p || pmp) begin
        if (op == 0 && cp) begin kind = 2; tag = "R6"; end
        else begin kind = 1; nv = (op == 0); end
      end
    end else if (op == 2) begin
      tag = "R11";
      if (!flt) kind = 0;
      else if (v86p) begin kind = 0; img_if = cv; end
    end else if (op == 3) begin
      if (!flt) begin kind = 1; ni = pop; end
      else if (v86p) begin
        if (pop && cp) tag = "R6";
        else begin kind = 1; nv = pop; end
      end
    end else if (op == 4) begin
      if (!flt) begin kind = 1; ni = pop; end
    end else begin
      tag = "R9";
      if (!flt) begin kind = 1; gate = 1; ni = 0; end
      else if (v86p) begin kind = 1; gate = 1; nv = 0; end
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flag_if == 0 && flag_vif == 0 && flag_vip == 0, "R1", "flags after reset",
          {flag_if, flag_vif, flag_vip}, 0);
    check(res_valid == 0 && op_ready == 1, "R1", "stream after reset",
          {res_valid, op_ready}, 1);
    rst_n = 1'b1;

    // Near-exhaustive sweep.
    for (int op = 0; op < 6; op++)
      for (int pop = 0; pop < ((op == 3 || op == 4) ? 2 : 1); pop++)
        for (int mode = 0; mode < 4; mode++)
          for (int cpl = 0; cpl < 4; cpl++)
            for (int iopl = 0; iopl < 4; iopl++)
              for (int cr4 = 0; cr4 < 4; cr4++)
                for (int st = 0; st < 8; st++) begin
                  int kind; bit ni, nv, gt, ii; string tag;
                  bit ci, cv, cp;
                  ci = st[2]; cv = st[1]; cp = st[0];
                  put_state(ci, cv, cp);
                  model(op, mode, cpl, iopl, cr4, ci, cv, cp, pop[0],
                        kind, ni, nv, gt, ii, tag);
                  issue(op, mode, cpl, iopl, cr4, pop[0], 8'h40 + op);
                  if (!(res_valid && res_kind == 2'(kind) && flag_if == ni &&
                        flag_vif == nv && res_gate == gt && flag_vip == cp &&
                        res_image[9] == ii && res_image[19] == cv &&
                        res_image[20] == cp))
                    check(1'b0, tag,
                          $sformatf("op%0d m%0d c%0d io%0d cr%0d st%0d {kind,if,vif,gate,img}",
                                    op, mode, cpl, iopl, cr4, st),
                          {res_kind, flag_if, flag_vif, res_gate, res_image[9]},
                          {2'(kind), ni, nv, gt, ii});
                  else
                    check(1'b1, tag, "sweep", 0, 0);
                end

    // R9 vector passes through on gate delivery.
    issue(5, 1, 0, 0, 0, 1'b0, 8'hA7);
    check(res_gate == 1 && res_vector == 8'hA7, "R9", "vector", res_vector, 8'hA7);

    // R12 image bits other than 9,19,20 are zero.
    put_state(1, 1, 1);
    issue(2, 0, 0, 0, 0, 1'b0, 0);
    check(res_image == 32'h0018_0200, "R12", "image layout", res_image, 32'h0018_0200);

    // R10 VIP write wins while an instruction executes.
    put_state(0, 0, 0);
    @(negedge clk);
    sw_vip_we = 1'b1; sw_vip_val = 1'b1; op_valid = 1'b1;
    op_class = 3'd0; op_mode = 2'd2; op_iopl = 2'd0; cr4_en = 2'b01;
    @(posedge clk);
    @(negedge clk);
    sw_vip_we = 1'b0; op_valid = 1'b0;
    check(flag_vip == 1 && flag_vif == 1, "R10", "vip write with op",
          {flag_vip, flag_vif}, 3);

    // R2 back-pressure.
    put_state(0, 0, 0);
    @(negedge clk);
    res_ready = 1'b0;
    issue(0, 0, 0, 0, 0, 1'b0, 0);
    check(res_valid == 1 && op_ready == 0, "R2", "stalled ready", op_ready, 0);
    @(negedge clk);
    op_class = 3'd1; op_mode = 2'd0; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(flag_if == 1 && res_kind == 2'd1, "R2", "op blocked while stalled",
          flag_if, 1);
    res_ready = 1'b1;
    @(negedge clk);
    check(res_valid == 0 && op_ready == 1, "R2", "drain", res_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule